// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block runs on the host side of a flash device and works out whether a program or erase operation has finished. A `start` pulse begins the polling. The controller then issues single reads through a request/acknowledge read port that returns 8 data bits. For each pair of reads in a row, it compares the toggle bit of the second read with the toggle bit of the first. A toggle bit that holds still means the operation is complete.

A toggle bit that keeps changing leads the controller to look at the timeout flag in the latest read. If the flag is clear, the controller starts a fresh pair of reads. If the flag is set, the controller makes one more back-to-back pair of reads before it decides the outcome. This covers the race where the toggling stops in the same cycle that the timeout flag rises.

A failed operation makes the controller issue one command write of the reset code, which sends the device back to array reads. It then reports the result with a one-cycle `done` pulse and a `fail` level. A host-programmed iteration limit makes the controller give up on a device that never settles. An abort input makes it leave polling without reporting a result.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Each status check is two reads in a row. When bit 6 (the toggle bit) of the second read equals bit 6 of the first, the controller ends with `done` high and `fail` low. No other data bit changes the decision.
- R2: When bit 6 differs and bit 5 (the timeout flag) of the second read is 0, the controller starts a new pair of reads. The new pair compares only its own two reads.
- R3: When bit 6 differs and bit 5 of the second read is 1, the controller makes exactly one further pair of reads. If bit 6 is equal across that pair, the result is success, whatever bit 5 holds in it. This pair takes priority over the iteration limit.
- R4: When the recheck pair still toggles, the controller holds `wr_req` with `wr_data` = 8'hF0 until `wr_ack`. It then ends with `done` and `fail` both high.
- R5: `max_iter` is sampled at `start`. When pair number `max_iter` ends toggling with bit 5 low, the controller issues the reset write of R4 and fails. A value of 0 acts as 1.
- R6: `done` is high for exactly one cycle per completed operation, with no request active. `fail` keeps its value until the next accepted `start`, which clears it.
- R7: `array_ready` rises together with a successful `done`. It is cleared by an accepted `start` and is never high together with `fail`.
- R8: `abort` during polling returns the controller to idle with no `done` and no write. The next `start` begins with a fresh pair of reads.
- R9: After reset no request is active. `rd_req` and `wr_req` are never high together, and each stays high until its acknowledge or an abort.
- R10: `start` while polling is ignored. The operation in progress keeps its read count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (accepted in idle only) |
| abort | input | 1 | Leave polling without a result |
| max_iter | input | 16 | Maximum number of read pairs, sampled at start |
| rd_req | output | 1 | Read request, held until rd_ack |
| rd_ack | input | 1 | Read acknowledge, rd_data valid with it |
| rd_data | input | 8 | Read data from the device |
| wr_req | output | 1 | Command write request, held until wr_ack |
| wr_ack | input | 1 | Command write acknowledge |
| wr_data | output | 8 | Command write data (reset code 8'hF0) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last operation, 1 = failure |
| array_ready | output | 1 | Device is back to array reads after a success |

## Verification
A request reaches its port on the clock edge that follows the accepted `start` or the previous acknowledge. `done`, `fail` and `array_ready` change on the edge that captures the deciding read acknowledge or the write acknowledge. The bench drives and samples on falling edges only. It answers a request seen at one falling edge with an acknowledge that the next rising edge captures, and it expects the result one falling edge after the last acknowledge. It checks that `done` has dropped one falling edge after that. Read and write counts are tallied at the same falling edges, so an extra or a missing read shows up as a count mismatch.

// File: rtl/tpc_pkg.sv
// Package: shared types for the toggle bit polling controller.
// Assumes: one read or one write in flight at a time.
package tpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CHK_A,
        ST_CHK_B,
        ST_RST_WR
    } tpc_state_e;
endpackage

// File: rtl/tpc_judge.sv
// Module: tpc_judge
// Decides, for the second read of a pair, whether the toggle bit moved and
// whether the timeout flag is set. Purely combinational.
// Assumes: first_tog holds the toggle bit of the first read of the pair.
module tpc_judge #(
    parameter int DATA_W  = 8,
    parameter int TOG_BIT = 6,
    parameter int LIM_BIT = 5
) (
    input  logic              first_tog,
    input  logic [DATA_W-1:0] data,
    output logic              toggling,
    output logic              limit_hit
);
    // Compare toggle bit and pick out the timeout flag of the latest read.
    always_comb begin
        toggling  = data[TOG_BIT] ^ first_tog;
        limit_hit = data[LIM_BIT];
    end
endmodule

// File: rtl/tpc_iter_cnt.sv
// Module: tpc_iter_cnt
// Counts top-level read pairs that ended toggling with the timeout flag low,
// against a limit captured at load. 'last' says the pair now ending is the
// final one allowed. A limit of 0 behaves as 1.
// Assumes: load and step are never high in the same cycle.
module tpc_iter_cnt #(
    parameter int ITER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ITER_W-1:0] lim_in,
    input  logic              step,
    output logic              last
);
    localparam int CW = ITER_W + 1;

    logic [ITER_W-1:0] cnt_q;
    logic [ITER_W-1:0] lim_q;

    // Hold the pair count and the captured limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The pair in progress is the last one when its number reaches the limit.
    always_comb begin
        last = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, lim_q};
    end
endmodule

// File: rtl/toggle_poll_ctrl.sv
// Module: toggle_poll_ctrl (top)
// Polls a flash device by toggle bit comparison of read pairs, rechecks
// once when the timeout flag is seen, writes the reset code on failure and
// reports a one-cycle done with a held fail level.
// Assumes: rd_data is valid in the cycle rd_ack is high; acks only answer
// an active request; reads and writes need no address.
module toggle_poll_ctrl #(
    parameter int              DATA_W    = 8,
    parameter int              TOG_BIT   = 6,
    parameter int              LIM_BIT   = 5,
    parameter int              ITER_W    = 16,
    parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ITER_W-1:0] max_iter,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic              fail,
    output logic              array_ready
);
    import tpc_pkg::*;

    tpc_state_e state_q;
    logic       first_tog_q;
    logic       toggling;
    logic       limit_hit;
    logic       last_pair;
    logic       busy;
    logic       cnt_load;
    logic       cnt_step;

    tpc_judge #(
        .DATA_W (DATA_W),
        .TOG_BIT(TOG_BIT),
        .LIM_BIT(LIM_BIT)
    ) u_judge (
        .first_tog(first_tog_q),
        .data     (rd_data),
        .toggling (toggling),
        .limit_hit(limit_hit)
    );

    tpc_iter_cnt #(
        .ITER_W(ITER_W)
    ) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .lim_in(max_iter),
        .step  (cnt_step),
        .last  (last_pair)
    );

    // Port requests and counter controls decoded from the state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        rd_req   = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                   (state_q == ST_CHK_A) || (state_q == ST_CHK_B);
        wr_req   = (state_q == ST_RST_WR);
        wr_data  = RESET_CMD;
        cnt_load = (state_q == ST_IDLE) && start;
        cnt_step = (state_q == ST_RD_B) && rd_ack && !abort &&
                   toggling && !limit_hit;
    end

    // Polling sequence, result flags and stored toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            first_tog_q <= 1'b0;
            done        <= 1'b0;
            fail        <= 1'b0;
            array_ready <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy && abort) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            state_q     <= ST_RD_A;
                            first_tog_q <= 1'b0;
                            fail        <= 1'b0;
                            array_ready <= 1'b0;
                        end
                    end
                    ST_RD_A, ST_CHK_A: begin
                        if (rd_ack) begin
                            first_tog_q <= rd_data[TOG_BIT];
                            state_q     <= (state_q == ST_RD_A) ? ST_RD_B : ST_CHK_B;
                        end
                    end
                    ST_RD_B: begin
                        if (rd_ack) begin
                            if (!toggling) begin
                                state_q     <= ST_IDLE;
                                done        <= 1'b1;
                                array_ready <= 1'b1;
                            end else if (limit_hit) begin
                                state_q <= ST_CHK_A;
                            end else if (last_pair) begin
                                state_q <= ST_RST_WR;
                            end else begin
                                state_q <= ST_RD_A;
                            end
                        end
                    end
                    ST_CHK_B: begin
                        if (rd_ack) begin
                            if (!toggling) begin
                                state_q     <= ST_IDLE;
                                done        <= 1'b1;
                                array_ready <= 1'b1;
                            end else begin
                                state_q <= ST_RST_WR;
                            end
                        end
                    end
                    ST_RST_WR: begin
                        if (wr_ack) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                            fail    <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
// Module: toggle_poll_ctrl_chk
// Port-level protocol checks for toggle_poll_ctrl, attached by bind.
module toggle_poll_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int ITER_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              abort,
    input logic [ITER_W-1:0] max_iter,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [DATA_W-1:0] wr_data,
    input logic              done,
    input logic              fail,
    input logic              array_ready
);
    assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !abort) |=> rd_req);

    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !abort) |=> wr_req);

    assert_wr_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_data == 8'hF0));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_req && !wr_req));

    assert_fail_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail) |-> (done || $past(start)));

    assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(array_ready && fail));
endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(
    .DATA_W(DATA_W),
    .ITER_W(ITER_W)
) u_chk (.*);

// File: tb/toggle_poll_ctrl_tb.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [15:0] max_iter = 16'd4;
    logic        rd_req;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        wr_req;
    logic        wr_ack = 1'b0;
    logic [7:0]  wr_data;
    logic        done;
    logic        fail;
    logic        array_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    toggle_poll_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .max_iter(max_iter), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .wr_req(wr_req), .wr_ack(wr_ack),
        .wr_data(wr_data), .done(done), .fail(fail),
        .array_ready(array_ready)
    );

    // Vector: {reads[3:0], seq[15:0], lim[3:0], exp_fail, exp_wr}.
    // Read k uses seq[2k+1] as bit 6 and seq[2k] as bit 5.
    localparam int NV = 10;
    localparam logic [25:0] VEC [NV] = '{
        {4'd2, 16'h0000, 4'd4, 1'b0, 1'b0},  // R1 stable at once
        {4'd4, 16'h00A8, 4'd4, 1'b0, 1'b0},  // R2 toggle, flag low, new pair
        {4'd4, 16'h00AC, 4'd4, 1'b0, 1'b0},  // R3 flag high, recheck stable
        {4'd4, 16'h00CC, 4'd4, 1'b1, 1'b1},  // R4 recheck still toggles
        {4'd4, 16'h0088, 4'd2, 1'b1, 1'b1},  // R5 limit 2 reached
        {4'd2, 16'h0008, 4'd0, 1'b1, 1'b1},  // R5 limit 0 acts as 1
        {4'd4, 16'h00A9, 4'd4, 1'b0, 1'b0},  // R2 flag only on first read
        {4'd6, 16'h0022, 4'd5, 1'b0, 1'b0},  // R2 two toggling pairs
        {4'd4, 16'h0056, 4'd4, 1'b0, 1'b0},  // R3 flag high in recheck too
        {4'd4, 16'h00AC, 4'd1, 1'b0, 1'b0}   // R3 recheck before limit
    };

    function automatic logic [7:0] enc(input logic [15:0] seq, input int idx);
        if (idx < 8) return {1'b1, seq[2*idx+1], seq[2*idx], 5'b10101};
        return 8'h95;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive start and answer requests until done; returns read/write counts.
    task automatic run_op(input logic [15:0] seq, output int nrd, output int nwr,
                          output logic got);
        nrd = 0; nwr = 0; got = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 100; c++) begin
            if (done) begin got = 1'b1; break; end
            rd_ack = 1'b0; wr_ack = 1'b0;
            if (rd_req) begin
                rd_ack = 1'b1; rd_data = enc(seq, nrd); nrd++;
            end
            if (wr_req) begin
                check(wr_data == 8'hF0, "R4 wr_data", int'(wr_data), 240);
                wr_ack = 1'b1; nwr++;
            end
            @(negedge clk);
        end
        rd_ack = 1'b0; wr_ack = 1'b0;
    endtask

    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nrd, nwr;
        logic got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!rd_req && !wr_req && !done && !fail && !array_ready,
              "R9 reset outputs", int'({rd_req, wr_req, done, fail, array_ready}), 0);

        for (int v = 0; v < NV; v++) begin
            max_iter = {12'd0, VEC[v][5:2]};
            run_op(VEC[v][21:6], nrd, nwr, got);
            check(got, "R6 done seen", int'(got), 1);
            check(nrd == int'(VEC[v][25:22]), "R1 R2 R3 R5 read count", nrd, int'(VEC[v][25:22]));
            check(nwr == int'(VEC[v][0]), "R4 write count", nwr, int'(VEC[v][0]));
            check(fail == VEC[v][1], "R4 R5 fail", int'(fail), int'(VEC[v][1]));
            check(array_ready == !VEC[v][1], "R7 array_ready", int'(array_ready), int'(!VEC[v][1]));
            @(negedge clk);
            check(!done, "R6 done one cycle", int'(done), 0);
        end

        // R6 fail held, then cleared with array_ready by a new start (R7)
        max_iter = 16'd4;
        run_op(16'h00CC, nrd, nwr, got);
        repeat (3) @(negedge clk);
        check(fail, "R6 fail held", int'(fail), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!fail && !array_ready && rd_req, "R6 R7 cleared at start",
              int'({fail, array_ready, rd_req}), 1);
        // R8 abort from the second read of a pair
        rd_ack = 1'b1; rd_data = enc(16'h0000, 0);
        @(negedge clk);
        rd_ack = 1'b0; abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(!rd_req && !wr_req && !done, "R8 abort to idle",
              int'({rd_req, wr_req, done}), 0);
        // R8 fresh pair: bit 6 of the new reads is 1, stale value was 0
        run_op(16'h000A, nrd, nwr, got);
        check(got && !fail && nrd == 2, "R8 fresh pair reads", nrd, 2);

        // R10 start during polling is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rd_ack = 1'b1; rd_data = enc(16'h0000, 0);
        @(negedge clk);
        rd_ack = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(rd_req, "R10 still polling", int'(rd_req), 1);
        rd_ack = 1'b1; rd_data = enc(16'h0000, 1);
        @(negedge clk);
        rd_ack = 1'b0;
        check(done && !fail && !rd_req, "R10 ends after two reads",
              int'({done, fail, rd_req}), 4);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule